// File: doc/BRIEF.md
# Register-Controlled Barrel Shifter with Carry Flag

This block shifts or rotates a 32-bit operand by an amount taken from a general-purpose register and produces the carry flag that the operation leaves behind. Only the least significant byte of the 32-bit control word sets the distance, so distances from 0 up to 255 are legal. Each operation has its own rule for result and carry once the distance reaches or passes the word width.

The datapath is purely combinational. An execute stage presents the operand, the control word, a 2-bit operation code and the current carry flag. It takes the result and the new carry in the same cycle. The operation code is 0 for logical left, 1 for logical right, 2 for arithmetic right and 3 for rotate right.

Internally the byte distance is first sorted into one of four classes: none (0), partial (1 to 31), full (exactly 32) and over (33 to 255). One log-depth barrel network serves all four operations. Left shifts pass through it in bit-reversed form. A separate selector picks the carry from the class and the operation.

Top module: `shf_reg_shifter`

## Requirements
- R1: Only bits 7:0 of `ctrl_i` set the distance. Bits 31:8 have no effect on either output.
- R2: With a distance of 0, `result_o` equals `opnd_i` and `carry_o` equals `carry_i` for all four operation codes.
- R3: Logical left (code 0) by 1 to 31 gives the operand shifted left with zero fill. The carry is operand bit (32 - distance).
- R4: Logical left by exactly 32 gives result 0 with carry equal to operand bit 0. Above 32 it gives result 0 and carry 0.
- R5: Logical right (code 1) by 1 to 31 gives the operand shifted right with zero fill. The carry is operand bit (distance - 1).
- R6: Logical right by exactly 32 gives result 0 with carry equal to operand bit 31. Above 32 it gives result 0 and carry 0.
- R7: Arithmetic right (code 2) by 1 to 31 fills with operand bit 31. The carry is operand bit (distance - 1).
- R8: Arithmetic right by 32 or more gives 32 copies of operand bit 31, and the carry equals operand bit 31.
- R9: Rotate right (code 3) turns the operand by (distance mod 32). When that remainder is 1 to 31, the carry is operand bit (remainder - 1).
- R10: Rotate right by a non-zero distance that is a multiple of 32 returns the operand unchanged, and the carry equals operand bit 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 32 | Operand to shift or rotate |
| ctrl_i | input | 32 | Control register word; bits 7:0 give the distance |
| op_i | input | 2 | Operation code: 0 left, 1 logical right, 2 arithmetic right, 3 rotate right |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted or rotated operand |
| carry_o | output | 1 | Updated carry flag |

## Verification
The block holds no state. A wrong distance class or a miswired barrel stage therefore shows at the outputs in the same cycle the inputs are applied. A mistake confined to a single class only appears when a distance from that class is driven. For that reason the stimulus covers the distances 0, 1, 31, 32, 33 and 255 for every operation. Random operands are needed to expose a carry taken from the wrong bit position, because that fault is masked whenever neighbouring operand bits happen to be equal.

// File: rtl/shf_pkg.sv
package shf_pkg;

    typedef enum logic [1:0] {
        OP_LSL = 2'd0,
        OP_LSR = 2'd1,
        OP_ASR = 2'd2,
        OP_ROR = 2'd3
    } shf_op_e;

    // Distance class relative to the word width
    typedef enum logic [1:0] {
        AMT_NONE = 2'd0,
        AMT_PART = 2'd1,
        AMT_FULL = 2'd2,
        AMT_OVER = 2'd3
    } shf_amt_e;

    localparam int unsigned AMT_W = 8;

endpackage

// File: rtl/shf_amount_class.sv
module shf_amount_class
    import shf_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [AMT_W-1:0]     amt_i,
    output shf_amt_e             cls_o,
    output logic [$clog2(W)-1:0] low_o
);
    localparam int unsigned SH_W = $clog2(W);
    localparam logic [AMT_W-1:0] W_AMT = AMT_W'(W);

    assign low_o = amt_i[SH_W-1:0];

    always_comb begin
        if (amt_i == '0)          cls_o = AMT_NONE;
        else if (amt_i < W_AMT)   cls_o = AMT_PART;
        else if (amt_i == W_AMT)  cls_o = AMT_FULL;
        else                      cls_o = AMT_OVER;
    end
endmodule

// File: rtl/shf_barrel.sv
module shf_barrel #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0]         data_i,
    input  logic [$clog2(W)-1:0] sh_i,
    input  logic                 left_i,
    input  logic                 arith_i,
    input  logic                 rot_i,
    output logic [W-1:0]         data_o
);
    localparam int unsigned SH_W = $clog2(W);

    logic [W-1:0] rev_in;
    logic [W-1:0] rev_out;
    logic [W-1:0] stage [0:SH_W];
    logic         fill;

    // Left shifts run through the right-shift network bit-reversed
    for (genvar b = 0; b < W; b++) begin : g_rev
        assign rev_in[b]  = data_i[W-1-b];
        assign rev_out[b] = stage[SH_W][W-1-b];
    end

    assign fill     = arith_i & ~left_i & data_i[W-1];
    assign stage[0] = left_i ? rev_in : data_i;

    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        localparam int unsigned D = 1 << k;
        assign stage[k+1] = !sh_i[k] ? stage[k] :
                            rot_i    ? {stage[k][D-1:0], stage[k][W-1:D]} :
                                       {{D{fill}}, stage[k][W-1:D]};
    end

    assign data_o = left_i ? rev_out : stage[SH_W];
endmodule

// File: rtl/shf_carry_pick.sv
module shf_carry_pick
    import shf_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0]         opnd_i,
    input  shf_op_e              op_i,
    input  shf_amt_e             cls_i,
    input  logic [$clog2(W)-1:0] low_i,
    input  logic                 carry_i,
    output logic                 carry_o
);
    localparam int unsigned SH_W = $clog2(W);

    logic [SH_W:0]   left_idx;
    logic [SH_W-1:0] right_idx;
    logic            left_bit;
    logic            right_bit;

    assign left_idx  = (SH_W+1)'(W) - {1'b0, low_i};
    assign right_idx = low_i - SH_W'(1);
    assign left_bit  = opnd_i[left_idx[SH_W-1:0]];
    assign right_bit = opnd_i[right_idx];

    always_comb begin
        carry_o = carry_i;
        if (cls_i != AMT_NONE) begin
            unique case (op_i)
                OP_LSL: begin
                    unique case (cls_i)
                        AMT_PART: carry_o = left_bit;
                        AMT_FULL: carry_o = opnd_i[0];
                        default:  carry_o = 1'b0;
                    endcase
                end
                OP_LSR: begin
                    unique case (cls_i)
                        AMT_PART: carry_o = right_bit;
                        AMT_FULL: carry_o = opnd_i[W-1];
                        default:  carry_o = 1'b0;
                    endcase
                end
                OP_ASR: carry_o = (cls_i == AMT_PART) ? right_bit : opnd_i[W-1];
                OP_ROR: carry_o = (low_i == '0) ? opnd_i[W-1] : right_bit;
            endcase
        end
    end
endmodule

// File: rtl/shf_reg_shifter.sv
module shf_reg_shifter
    import shf_pkg::*;
#(
    parameter int unsigned W      = 32,
    parameter int unsigned CTRL_W = 32
) (
    input  logic [W-1:0]      opnd_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic [1:0]        op_i,
    input  logic              carry_i,
    output logic [W-1:0]      result_o,
    output logic              carry_o
);
    localparam int unsigned SH_W = $clog2(W);

    shf_op_e         op;
    shf_amt_e        cls;
    logic [SH_W-1:0] low;
    logic [W-1:0]    barrel_out;

    assign op = shf_op_e'(op_i);

    shf_amount_class #(.W(W)) u_class (
        .amt_i (ctrl_i[AMT_W-1:0]),
        .cls_o (cls),
        .low_o (low)
    );

    shf_barrel #(.W(W)) u_barrel (
        .data_i  (opnd_i),
        .sh_i    (low),
        .left_i  (op == OP_LSL),
        .arith_i (op == OP_ASR),
        .rot_i   (op == OP_ROR),
        .data_o  (barrel_out)
    );

    shf_carry_pick #(.W(W)) u_carry (
        .opnd_i  (opnd_i),
        .op_i    (op),
        .cls_i   (cls),
        .low_i   (low),
        .carry_i (carry_i),
        .carry_o (carry_o)
    );

    always_comb begin
        result_o = opnd_i;
        if (cls != AMT_NONE) begin
            unique case (op)
                OP_LSL, OP_LSR: result_o = (cls == AMT_PART) ? barrel_out : '0;
                OP_ASR:         result_o = (cls == AMT_PART) ? barrel_out : {W{opnd_i[W-1]}};
                OP_ROR:         result_o = barrel_out;
            endcase
        end
    end
endmodule

// File: rtl/shf_reg_shifter_chk.sv
module shf_reg_shifter_chk #(
    parameter int unsigned W      = 32,
    parameter int unsigned CTRL_W = 32
) (
    input logic [W-1:0]      opnd_i,
    input logic [CTRL_W-1:0] ctrl_i,
    input logic [1:0]        op_i,
    input logic              carry_i,
    input logic [W-1:0]      result_o,
    input logic              carry_o
);
    logic [7:0] amt;
    logic       known;

    assign amt   = ctrl_i[7:0];
    assign known = !$isunknown({opnd_i, ctrl_i, op_i, carry_i});

    always_comb begin
        if (known) begin
            if (amt == 8'd0)
                assert_zero_passthru_R2: assert (result_o == opnd_i && carry_o == carry_i);
            if (op_i == 2'd0 && amt > 8'(W))
                assert_left_over_clear_R4: assert (result_o == '0 && carry_o == 1'b0);
            if (op_i == 2'd1 && amt > 8'(W))
                assert_right_over_clear_R6: assert (result_o == '0 && carry_o == 1'b0);
            if (op_i == 2'd2 && amt >= 8'(W))
                assert_arith_sign_fill_R8: assert (result_o == {W{opnd_i[W-1]}} && carry_o == opnd_i[W-1]);
            if (op_i == 2'd3 && amt != 8'd0)
                assert_rot_carry_top_R9: assert (carry_o == result_o[W-1]);
            if (op_i == 2'd3 && amt != 8'd0 && amt[4:0] == 5'd0)
                assert_rot_whole_turn_R10: assert (result_o == opnd_i && carry_o == opnd_i[W-1]);
        end
    end
endmodule

bind shf_reg_shifter shf_reg_shifter_chk #(.W(W), .CTRL_W(CTRL_W)) u_chk (
    .opnd_i   (opnd_i),
    .ctrl_i   (ctrl_i),
    .op_i     (op_i),
    .carry_i  (carry_i),
    .result_o (result_o),
    .carry_o  (carry_o)
);

// File: tb/tb_shf_reg_shifter.sv
module tb_shf_reg_shifter;

    typedef struct {
        logic [31:0] res;
        logic        cy;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd;
    logic [31:0] ctrl;
    logic [1:0]  op;
    logic        cin;
    logic [31:0] res;
    logic        cout;

    exp_t exp_q[$];
    int   n_cmp  = 0;
    int   n_bad  = 0;
    bit   drv_done = 1'b0;

    always #5 clk = ~clk;

    shf_reg_shifter dut (
        .opnd_i   (opnd),
        .ctrl_i   (ctrl),
        .op_i     (op),
        .carry_i  (cin),
        .result_o (res),
        .carry_o  (cout)
    );

    // Independent reference using double-width arithmetic
    function automatic exp_t model(logic [31:0] a, logic [31:0] c, logic [1:0] o, logic ci);
        exp_t e;
        int   n;
        logic [63:0] wide;
        n = int'(c[7:0]);
        e.tag = "";
        if (n == 0) begin
            e.res = a; e.cy = ci;
        end else begin
            case (o)
                2'd0: begin
                    wide = {32'd0, a} << n;
                    e.res = wide[31:0]; e.cy = wide[32];
                end
                2'd1: begin
                    wide = {a, 32'd0} >> n;
                    e.res = wide[63:32]; e.cy = wide[31];
                end
                2'd2: begin
                    wide = 64'($signed({a, 32'd0}) >>> n);
                    e.res = wide[63:32]; e.cy = wide[31];
                end
                default: begin
                    wide = {a, a} >> (n % 32);
                    e.res = wide[31:0]; e.cy = wide[31];
                end
            endcase
        end
        return e;
    endfunction

    function automatic string tag_of(logic [1:0] o, int n);
        if (n == 0) return "R2";
        case (o)
            2'd0:    return (n < 32) ? "R3" : "R4";
            2'd1:    return (n < 32) ? "R5" : "R6";
            2'd2:    return (n < 32) ? "R7" : "R8";
            default: return (n % 32 != 0) ? "R9" : "R10";
        endcase
    endfunction

    task automatic drive(logic [31:0] a, logic [31:0] c, logic [1:0] o, logic ci, string tag);
        exp_t e;
        @(negedge clk);
        opnd = a; ctrl = c; op = o; cin = ci;
        e = model(a, c, o, ci);
        e.tag = (tag == "") ? tag_of(o, int'(c[7:0])) : tag;
        exp_q.push_back(e);
    endtask

    // Monitor: inputs settle at the falling edge, compared at the rising edge
    always @(posedge clk) begin
        if (rst_n && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_cmp++;
            if (res !== e.res || cout !== e.cy) begin
                n_bad++;
                $display("FAIL %s: op=%0d amt=%0d got res=%h cy=%b expected res=%h cy=%b",
                         e.tag, op, ctrl[7:0], res, cout, e.res, e.cy);
            end
        end
    end

    initial begin
        int amts[6] = '{0, 1, 31, 32, 33, 255};
        opnd = '0; ctrl = '0; op = '0; cin = 1'b0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // Idle state: zero distance passes operand and carry through (R2)
        drive(32'h0000_0000, 32'h0, 2'd0, 1'b0, "R2");
        drive(32'hDEAD_BEEF, 32'h0, 2'd3, 1'b1, "R2");
        // Directed corners
        drive(32'h8000_0001, 32'd1,  2'd0, 1'b0, "R3");
        drive(32'h0000_0001, 32'd32, 2'd0, 1'b0, "R4");
        drive(32'hFFFF_FFFF, 32'd33, 2'd0, 1'b1, "R4");
        drive(32'h0000_0001, 32'd1,  2'd1, 1'b0, "R5");
        drive(32'h8000_0000, 32'd32, 2'd1, 1'b0, "R6");
        drive(32'hFFFF_FFFF, 32'd40, 2'd1, 1'b1, "R6");
        drive(32'h8000_0010, 32'd4,  2'd2, 1'b0, "R7");
        drive(32'h8000_0000, 32'd200, 2'd2, 1'b0, "R8");
        drive(32'h0000_0001, 32'd1,  2'd3, 1'b0, "R9");
        drive(32'h8765_4321, 32'd64, 2'd3, 1'b0, "R10");
        // Upper control bits ignored (R1)
        drive(32'h1234_5678, 32'hFFFF_FF00, 2'd1, 1'b1, "R1");
        drive(32'h1234_5678, 32'hA5A5_A504, 2'd0, 1'b0, "R1");
        drive(32'hF000_0000, 32'h0101_0121, 2'd2, 1'b0, "R1");
        // Random operands over all corner distances and operations
        for (int i = 0; i < 60; i++) begin
            for (int o = 0; o < 4; o++) begin
                for (int k = 0; k < 6; k++) begin
                    drive($urandom, {$urandom() & 32'hFFFF_FF00} | 32'(amts[k]),
                          2'(o), 1'($urandom), "");
                end
            end
        end
        for (int i = 0; i < 400; i++)
            drive($urandom, $urandom, 2'($urandom), 1'($urandom), "");
        @(negedge clk);
        drv_done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!(drv_done && exp_q.size() == 0) && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (cyc >= 100000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule